// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline Core

This block is a small integer processor core with five pipeline stages: fetch, decode, execute, memory and writeback. It runs a reduced load/store instruction subset: register-register add, subtract, AND, OR and set-less-than, word load, word store, and branch-if-equal. Code and data memories sit outside the core on two separate buses. Instruction fetch reads over a combinational code bus. Loads read over a combinational data bus. Stores write on the clock edge at which the store leaves the memory stage.

Control bits are decoded once in decode and travel down the pipeline with the instruction. Each stage keeps only the bits it still needs. Branches are resolved in decode, using an equality compare whose operands can be forwarded from the memory stage. An internal hazard unit handles data hazards. It forwards results into execute and into the decode compare. It stalls fetch and decode for one cycle on a load followed by a use of the loaded value. It also stalls when a branch depends on a result that is not yet ready. A taken branch squashes the one instruction that was fetched behind it, so there is no delay slot.

Top module: `pipe5_core`

## Requirements
- R1: While rst_ni is low the code address is 0 and no store is issued. Reset clears all pipeline registers. The all-zero instruction decodes as a no-op, so no register or memory write occurs until real instructions reach those stages.
- R2: With no stall and no taken branch, the fetch address advances by 4 every cycle.
- R3: R-type instructions (opcode 0) write rd with one of these results: add (funct 32), sub (funct 34), and (funct 36), or (funct 37), or signed set-less-than (funct 42), which writes 1 or 0.
- R4: lw (opcode 35) and sw (opcode 43) use the address rs + sign-extended imm[15:0]. lw writes rt. sw drives rt onto the data write bus with the write strobe high for one cycle.
- R5: A result still in the memory or writeback stage is forwarded to a dependent instruction in execute, so back-to-back dependent instructions see the new value.
- R6: A load followed at once by an instruction that reads the loaded register holds fetch and decode for exactly one cycle, and the dependent instruction gets the loaded value. A branch that reads a register written by the instruction just ahead of it also holds for one cycle.
- R7: beq (opcode 4) with equal operands redirects fetch to the decode-stage PC+4 + (sign-extended imm << 2). The single instruction fetched behind the branch is discarded.
- R8: beq with unequal operands falls through with no lost instruction.
- R9: Register 0 always reads as zero. A write to it has no effect, and it is never a forwarding source.
- R10: A value being written back is visible to an instruction reading the same register in decode in that same cycle.
- R11: The self-test program ends by storing the value 7 to data address 84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Code fetch byte address (PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address from the memory stage |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, write on the rising clock edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |

## Verification
The assertions assume that the code bus returns a defined word for every fetched address. They also assume that reads of unwritten code locations return zero, which is a no-op. Both memory models return data in the same cycle as the address. The bench keeps to this by modelling both memories as preloaded arrays with combinational reads and by filling all unused code words with zero. The program ends in a branch-to-self loop, so fetch never leaves the preloaded region. Data addresses are word-aligned and stay inside the modelled array.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN  = 32;
  localparam int RF_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_to_reg;
    logic    mem_write;
    logic    alu_src;
    logic    reg_dst;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{reg_write: 1'b0, mem_to_reg: 1'b0, mem_write: 1'b0,
                                 alu_src: 1'b0, reg_dst: 1'b0, branch: 1'b0,
                                 alu_op: ALU_AND};
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = CTRL_NOP;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_write = 1'b1;
        ctrl_o.reg_dst   = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o = CTRL_NOP;  // unknown funct (incl. all-zero word) is a no-op
        endcase
      end
      OP_LOAD: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.alu_op     = ALU_ADD;
      end
      OP_STORE: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.alu_op    = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ctrl_o = CTRL_NOP;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra1_i,
  input  logic [AW-1:0]     ra2_i,
  input  logic [AW-1:0]     wa_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o
);
  logic [DATA_W-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // write-through so writeback is seen by decode in the same cycle
  function automatic logic [DATA_W-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)                 return '0;
    else if (we_i && wa_i == ra)  return wd_i;
    else                          return mem_q[ra];
  endfunction

  assign rd1_o = rd_port(ra1_i);
  assign rd2_o = rd_port(ra2_i);

  // R9
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra1_i == '0) |-> (rd1_o == '0));
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(DATA_W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_d_i,
  input  logic [AW-1:0] rt_d_i,
  input  logic          branch_d_i,
  input  logic [AW-1:0] rs_e_i,
  input  logic [AW-1:0] rt_e_i,
  input  logic [AW-1:0] wreg_e_i,
  input  logic          reg_write_e_i,
  input  logic          mem_to_reg_e_i,
  input  logic [AW-1:0] wreg_m_i,
  input  logic          reg_write_m_i,
  input  logic          mem_to_reg_m_i,
  input  logic [AW-1:0] wreg_w_i,
  input  logic          reg_write_w_i,
  output logic          stall_f_o,
  output logic          stall_d_o,
  output logic          flush_e_o,
  output logic          fwd_a_d_o,
  output logic          fwd_b_d_o,
  output logic [1:0]    fwd_a_e_o,
  output logic [1:0]    fwd_b_e_o
);
  // 2'b10 from memory stage, 2'b01 from writeback, 2'b00 register file
  function automatic logic [1:0] fwd_sel(input logic [AW-1:0] src);
    if (src != '0 && reg_write_m_i && src == wreg_m_i)      return 2'b10;
    else if (src != '0 && reg_write_w_i && src == wreg_w_i) return 2'b01;
    else                                                    return 2'b00;
  endfunction

  assign fwd_a_e_o = fwd_sel(rs_e_i);
  assign fwd_b_e_o = fwd_sel(rt_e_i);

  assign fwd_a_d_o = (rs_d_i != '0) && reg_write_m_i && (rs_d_i == wreg_m_i);
  assign fwd_b_d_o = (rt_d_i != '0) && reg_write_m_i && (rt_d_i == wreg_m_i);

  logic load_use, br_dep;
  assign load_use = mem_to_reg_e_i && rt_e_i != '0 &&
                    (rt_e_i == rs_d_i || rt_e_i == rt_d_i);
  assign br_dep = branch_d_i &&
                  ((reg_write_e_i && wreg_e_i != '0 &&
                    (wreg_e_i == rs_d_i || wreg_e_i == rt_d_i)) ||
                   (mem_to_reg_m_i && wreg_m_i != '0 &&
                    (wreg_m_i == rs_d_i || wreg_m_i == rt_d_i)));

  assign stall_f_o = load_use | br_dep;
  assign stall_d_o = load_use | br_dep;
  assign flush_e_o = load_use | br_dep;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] imem_addr_o,
  input  logic [31:0]       imem_data_i,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  output logic              dmem_we_o,
  input  logic [DATA_W-1:0] dmem_rdata_i
);
  logic stall_f, stall_d, flush_e, fwd_a_d, fwd_b_d;
  logic [1:0] fwd_a_e, fwd_b_e;

  // ---------------- fetch
  logic [DATA_W-1:0] pc_f, pc_plus4_f, pc_next, branch_tgt_d;
  logic pcsrc_d;

  assign pc_plus4_f = pc_f + DATA_W'(4);
  assign pc_next    = pcsrc_d ? branch_tgt_d : pc_plus4_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_f <= '0;
    else if (!stall_f) pc_f <= pc_next;
  end
  assign imem_addr_o = pc_f;

  // ---------------- fetch/decode register
  logic [31:0]       instr_d;
  logic [DATA_W-1:0] pc_plus4_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_d    <= '0;
      pc_plus4_d <= '0;
    end else if (!stall_d) begin
      if (pcsrc_d) begin
        instr_d    <= '0;
        pc_plus4_d <= '0;
      end else begin
        instr_d    <= imem_data_i;
        pc_plus4_d <= pc_plus4_f;
      end
    end
  end

  // ---------------- decode
  ctrl_t ctrl_d;
  logic [AW-1:0] rs_d, rt_d, rd_d;
  logic [DATA_W-1:0] imm_d, rd1_d, rd2_d, cmp_a, cmp_b;
  logic [DATA_W-1:0] alu_out_m, result_w;
  logic [AW-1:0] wreg_w;
  logic reg_write_w;

  assign rs_d  = instr_d[25:21];
  assign rt_d  = instr_d[20:16];
  assign rd_d  = instr_d[15:11];
  assign imm_d = {{(DATA_W-16){instr_d[15]}}, instr_d[15:0]};

  pipe5_ctrl u_ctrl (
    .opcode_i (instr_d[31:26]),
    .funct_i  (instr_d[5:0]),
    .ctrl_o   (ctrl_d)
  );

  pipe5_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs_d),
    .ra2_i  (rt_d),
    .wa_i   (wreg_w),
    .we_i   (reg_write_w),
    .wd_i   (result_w),
    .rd1_o  (rd1_d),
    .rd2_o  (rd2_d)
  );

  assign cmp_a        = fwd_a_d ? alu_out_m : rd1_d;
  assign cmp_b        = fwd_b_d ? alu_out_m : rd2_d;
  assign pcsrc_d      = ctrl_d.branch && (cmp_a == cmp_b);
  assign branch_tgt_d = pc_plus4_d + {imm_d[DATA_W-3:0], 2'b00};

  // ---------------- decode/execute register
  ctrl_t ctrl_e;
  logic [DATA_W-1:0] rd1_e, rd2_e, imm_e;
  logic [AW-1:0] rs_e, rt_e, rd_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_e <= CTRL_NOP;
      rd1_e  <= '0;
      rd2_e  <= '0;
      imm_e  <= '0;
      rs_e   <= '0;
      rt_e   <= '0;
      rd_e   <= '0;
    end else if (flush_e) begin
      ctrl_e <= CTRL_NOP;
      rd1_e  <= '0;
      rd2_e  <= '0;
      imm_e  <= '0;
      rs_e   <= '0;
      rt_e   <= '0;
      rd_e   <= '0;
    end else begin
      ctrl_e <= ctrl_d;
      rd1_e  <= rd1_d;
      rd2_e  <= rd2_d;
      imm_e  <= imm_d;
      rs_e   <= rs_d;
      rt_e   <= rt_d;
      rd_e   <= rd_d;
    end
  end

  // ---------------- execute
  logic [DATA_W-1:0] src_a_e, wdata_e, src_b_e, alu_y_e;
  logic [AW-1:0] wreg_e;

  always_comb begin
    unique case (fwd_a_e)
      2'b10:   src_a_e = alu_out_m;
      2'b01:   src_a_e = result_w;
      default: src_a_e = rd1_e;
    endcase
    unique case (fwd_b_e)
      2'b10:   wdata_e = alu_out_m;
      2'b01:   wdata_e = result_w;
      default: wdata_e = rd2_e;
    endcase
  end

  assign src_b_e = ctrl_e.alu_src ? imm_e : wdata_e;
  assign wreg_e  = ctrl_e.reg_dst ? rd_e : rt_e;

  pipe5_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i  (src_a_e),
    .b_i  (src_b_e),
    .op_i (ctrl_e.alu_op),
    .y_o  (alu_y_e)
  );

  // ---------------- execute/memory register
  logic reg_write_m, mem_to_reg_m, mem_write_m;
  logic [DATA_W-1:0] wdata_m;
  logic [AW-1:0] wreg_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_write_m  <= 1'b0;
      mem_to_reg_m <= 1'b0;
      mem_write_m  <= 1'b0;
      alu_out_m    <= '0;
      wdata_m      <= '0;
      wreg_m       <= '0;
    end else begin
      reg_write_m  <= ctrl_e.reg_write;
      mem_to_reg_m <= ctrl_e.mem_to_reg;
      mem_write_m  <= ctrl_e.mem_write;
      alu_out_m    <= alu_y_e;
      wdata_m      <= wdata_e;
      wreg_m       <= wreg_e;
    end
  end

  assign dmem_addr_o  = alu_out_m;
  assign dmem_wdata_o = wdata_m;
  assign dmem_we_o    = mem_write_m;

  // ---------------- memory/writeback register
  logic mem_to_reg_w;
  logic [DATA_W-1:0] alu_out_w, rdata_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_write_w  <= 1'b0;
      mem_to_reg_w <= 1'b0;
      alu_out_w    <= '0;
      rdata_w      <= '0;
      wreg_w       <= '0;
    end else begin
      reg_write_w  <= reg_write_m;
      mem_to_reg_w <= mem_to_reg_m;
      alu_out_w    <= alu_out_m;
      rdata_w      <= dmem_rdata_i;
      wreg_w       <= wreg_m;
    end
  end

  assign result_w = mem_to_reg_w ? rdata_w : alu_out_w;

  // ---------------- hazard unit
  pipe5_hazard #(.AW(AW)) u_hazard (
    .rs_d_i         (rs_d),
    .rt_d_i         (rt_d),
    .branch_d_i     (ctrl_d.branch),
    .rs_e_i         (rs_e),
    .rt_e_i         (rt_e),
    .wreg_e_i       (wreg_e),
    .reg_write_e_i  (ctrl_e.reg_write),
    .mem_to_reg_e_i (ctrl_e.mem_to_reg),
    .wreg_m_i       (wreg_m),
    .reg_write_m_i  (reg_write_m),
    .mem_to_reg_m_i (mem_to_reg_m),
    .wreg_w_i       (wreg_w),
    .reg_write_w_i  (reg_write_w),
    .stall_f_o      (stall_f),
    .stall_d_o      (stall_d),
    .flush_e_o      (flush_e),
    .fwd_a_d_o      (fwd_a_d),
    .fwd_b_d_o      (fwd_b_d),
    .fwd_a_e_o      (fwd_a_e),
    .fwd_b_e_o      (fwd_b_e)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (pc_f == '0 && !mem_write_m && !reg_write_w));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_f && !pcsrc_d) |=> (pc_f == $past(pc_f) + DATA_W'(4)));

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_f |=> (pc_f == $past(pc_f) && instr_d == $past(instr_d)));

  // R7
  branch_squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcsrc_d && !stall_d) |=> (instr_d == '0 && pc_f == $past(branch_tgt_d)));
endmodule

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_data_i, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic dmem_we_o;

  always #2 clk_i = ~clk_i;

  pipe5_core u_pipe5_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_data_i  (imem_data_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] dinit [64];

  assign imem_data_i  = (imem_addr_o < 32'd256) ? imem[imem_addr_o[7:2]] : 32'd0;
  assign dmem_rdata_i = dmem[dmem_addr_o[7:2]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[7:2]] <= dmem_wdata_o;

  int checks = 0;
  int errors = 0;
  int exp_addr[$];
  int exp_data[$];
  logic seen84 = 1'b0;
  logic run_mon = 1'b0;
  int holds = 0;
  logic [31:0] prev_addr = 32'hFFFF_FFFF;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic string tag(input logic [31:0] a);
    case (a)
      32'd100: return "R5/R10";
      32'd124: return "R4/R6";
      32'd128: return "R9";
      32'd140: return "R8";
      32'd148: return "R7";
      32'd84:  return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dinit[i] = 32'd0; end
    dinit[0] = 32'd5; dinit[1] = 32'd12; dinit[2] = 32'd3; dinit[3] = 32'hFFFF_FFF9;
    imem[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    imem[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    imem[2]  = enc_i(6'd35, 5'd0, 5'd3, 16'd8);
    imem[3]  = enc_i(6'd35, 5'd0, 5'd4, 16'd12);
    imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'd32);        // add via writeback bypass
    imem[5]  = enc_i(6'd43, 5'd0, 5'd5, 16'd100);     // forwarded store data
    imem[6]  = enc_r(5'd2, 5'd1, 5'd6, 6'd34);
    imem[7]  = enc_i(6'd43, 5'd0, 5'd6, 16'd104);
    imem[8]  = enc_r(5'd1, 5'd2, 5'd7, 6'd36);
    imem[9]  = enc_r(5'd1, 5'd2, 5'd8, 6'd37);
    imem[10] = enc_r(5'd4, 5'd1, 5'd9, 6'd42);
    imem[11] = enc_r(5'd1, 5'd4, 5'd10, 6'd42);
    imem[12] = enc_i(6'd43, 5'd0, 5'd7, 16'd108);
    imem[13] = enc_i(6'd43, 5'd0, 5'd8, 16'd112);
    imem[14] = enc_i(6'd43, 5'd0, 5'd9, 16'd116);
    imem[15] = enc_i(6'd43, 5'd0, 5'd10, 16'd120);
    imem[16] = enc_i(6'd35, 5'd2, 5'd11, 16'hFFFC);   // negative offset
    imem[17] = enc_r(5'd11, 5'd11, 5'd12, 6'd32);     // load-use
    imem[18] = enc_i(6'd43, 5'd0, 5'd12, 16'd124);
    imem[19] = enc_r(5'd1, 5'd2, 5'd0, 6'd32);        // write to reg 0
    imem[20] = enc_i(6'd43, 5'd0, 5'd0, 16'd128);
    imem[21] = enc_i(6'd4, 5'd1, 5'd1, 16'd2);        // taken
    imem[22] = enc_i(6'd43, 5'd0, 5'd1, 16'd132);
    imem[23] = enc_i(6'd43, 5'd0, 5'd1, 16'd136);
    imem[24] = enc_i(6'd4, 5'd1, 5'd2, 16'd1);        // not taken
    imem[25] = enc_i(6'd43, 5'd0, 5'd2, 16'd140);
    imem[26] = enc_r(5'd3, 5'd1, 5'd13, 6'd32);
    imem[27] = enc_r(5'd13, 5'd1, 5'd14, 6'd34);
    imem[28] = enc_i(6'd4, 5'd14, 5'd3, 16'd1);       // taken, depends on previous
    imem[29] = enc_i(6'd43, 5'd0, 5'd1, 16'd144);
    imem[30] = enc_i(6'd43, 5'd0, 5'd14, 16'd148);
    imem[31] = enc_i(6'd43, 5'd0, 5'd6, 16'd84);
    imem[32] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);     // branch to self
    for (int i = 0; i < 64; i++) dmem[i] = dinit[i];
  endtask

  // architectural reference: one instruction per step, no pipeline
  task automatic run_model();
    logic [31:0] r [32];
    logic [31:0] m [64];
    int pc = 0;
    for (int i = 0; i < 32; i++) r[i] = 32'd0;
    for (int i = 0; i < 64; i++) m[i] = dinit[i];
    for (int step = 0; step < 200; step++) begin
      logic [31:0] ins, se, a, res;
      logic [4:0] rs, rt, rd;
      ins = imem[pc];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      se = {{16{ins[15]}}, ins[15:0]};
      a = r[rs] + se;
      pc = pc + 1;
      case (ins[31:26])
        6'd0: begin
          case (ins[5:0])
            6'd32: res = r[rs] + r[rt];
            6'd34: res = r[rs] - r[rt];
            6'd36: res = r[rs] & r[rt];
            6'd37: res = r[rs] | r[rt];
            6'd42: res = ($signed(r[rs]) < $signed(r[rt])) ? 32'd1 : 32'd0;
            default: res = r[rd];
          endcase
          if (rd != 5'd0) r[rd] = res;
        end
        6'd35: if (rt != 5'd0) r[rt] = m[a[7:2]];
        6'd43: begin
          m[a[7:2]] = r[rt];
          exp_addr.push_back(int'(a));
          exp_data.push_back(int'(r[rt]));
          if (a == 32'd84) break;
        end
        6'd4: if (r[rs] == r[rt]) pc = pc + int'($signed(se));
        default: ;
      endcase
    end
  endtask

  always @(negedge clk_i) begin
    if (run_mon && rst_ni) begin
      if (dmem_we_o) begin
        if (exp_addr.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s: actual store %0h<=%0h expected none", tag(dmem_addr_o),
                   dmem_addr_o, dmem_wdata_o);
        end else begin
          int ea, ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          check({tag(32'(ea)), " addr"}, dmem_addr_o, 32'(ea));
          check({tag(32'(ea)), " data"}, dmem_wdata_o, 32'(ed));
        end
        if (dmem_addr_o == 32'd84) seen84 = 1'b1;
      end
      if (!seen84 && imem_addr_o == prev_addr) holds++;
      prev_addr = imem_addr_o;
    end
  end

  initial begin
    int cyc;
    load_program();
    run_model();
    repeat (3) begin
      @(negedge clk_i);
      check("R1 reset pc", imem_addr_o, 32'd0);
      check("R1 reset store", {31'd0, dmem_we_o}, 32'd0);
    end
    #1 rst_ni = 1'b1;
    run_mon = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_i);
      check("R2 fetch addr", imem_addr_o, 32'(4 * k));
    end
    cyc = 0;
    while (!seen84 && cyc < 5000) begin
      @(negedge clk_i);
      cyc++;
    end
    if (!seen84) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual no store to 84 expected store of 7");
    end
    repeat (8) @(negedge clk_i);
    check("R11 pending stores", 32'(exp_addr.size()), 32'd0);
    check("R11 final value", dmem[21], 32'd7);
    check("R6 fetch hold cycles", 32'(holds), 32'd2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule